// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It receives single-cycle strobes marking the rising edges of the reference and feedback inputs of a phase-frequency detector, both already in the domain of a fast sampling clock. For every compare cycle it counts the sampling ticks between the two edges, whichever comes first. It then classifies the cycle against two programmable windows.

A narrow lock window decides whether a cycle is good. The lock flag rises only after a selectable run of consecutive good cycles. A wider unlock window decides when the flag drops: one cycle whose edge gap exceeds it clears the flag at once. Gaps that fall between the two windows neither build nor break an existing lock, so the flag does not chatter.

The block also measures the spacing of successive reference edges. It raises a configuration error when the compare period is not longer than the unlock window, or when the unlock window is not wider than the lock window. Deasserting the enable clears all state.

Top module: `pll_lock_monitor`

## Requirements
- R1: The edge gap of a compare cycle is the number of sampling-clock edges from the first edge strobe to the second, in either order. Strobes of both inputs in the same cycle give a gap of 0.
- R2: A compare cycle is good when its gap is strictly less than `lockWin`. `inWindow` pulses high for one cycle, one clock after the clock that samples the completing strobe, for good cycles only.
- R3: `locked` rises in the same cycle as the `inWindow` pulse of the good cycle that completes the required run of consecutive good cycles.
- R4: `countSel` picks the run length: 0 gives 5 cycles, 1 gives 16, 2 gives 64 and 3 gives 255.
- R5: While `locked` is high, a cycle whose gap is at least `lockWin` but not above `unlockWin` leaves it high. A cycle whose gap exceeds `unlockWin` clears it on that cycle's update.
- R6: Any cycle that is not good resets the consecutive-good count to zero, including a cycle between the two windows while unlocked.
- R7: If the second edge has not arrived `unlockWin`+1 ticks after the first, the cycle ends as a gap of `unlockWin`+1, which counts as beyond the unlock window.
- R8: `cfgError` is high while `unlockWin` is not greater than `lockWin`. It is also high after a reference edge that follows the previous one by `unlockWin` ticks or fewer, until a later reference edge with a longer spacing.
- R9: With `enable` low, `locked`, `inWindow` and the period error clear on the next clock and the measurement restarts. After reset the outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Detector enable; low clears all state |
| refEdge | input | 1 | One-cycle strobe on a reference rising edge |
| fbEdge | input | 1 | One-cycle strobe on a feedback rising edge |
| lockWin | input | WIN_W | Lock window in ticks (gap must be below it) |
| unlockWin | input | WIN_W | Unlock window in ticks (gap above it drops lock) |
| countSel | input | 2 | Selects the consecutive-good run length |
| locked | output | 1 | Lock flag with hysteresis |
| inWindow | output | 1 | One-cycle pulse per good compare cycle |
| cfgError | output | 1 | Window ordering or compare-period error |

## Verification
The properties assume that each edge strobe is a clean pulse of one cycle, and that the windows and selector stay steady while a compare cycle is in flight. The stimulus drives strobes only as single-cycle pulses set on the falling clock edge, and changes `lockWin`, `unlockWin` and `countSel` only in the idle gap after a cycle completes. Every compare cycle is followed by an idle gap of `unlockWin`+3 ticks, so the reference spacing stays legal except in the one directed case that provokes the period error.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  // Strobes sent from control to the measurement datapath
  typedef struct packed {
    logic clear;
  } lockCmd_t;

  // Strobes sent from the measurement datapath to control
  typedef struct packed {
    logic done;          // a compare cycle finished this cycle
    logic withinLock;    // its gap is below the lock window
    logic beyondUnlock;  // its gap is above the unlock window
  } measStat_t;

  typedef enum logic {
    MEAS_IDLE,
    MEAS_WAIT
  } measState_t;

  localparam int RUN_W = 8;

  // Required run of consecutive good compare cycles per selector value
  function automatic logic [RUN_W-1:0] runTarget(input logic [1:0] sel);
    case (sel)
      2'd0:    runTarget = 8'd5;
      2'd1:    runTarget = 8'd16;
      2'd2:    runTarget = 8'd64;
      default: runTarget = 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/lock_meas_path.sv
module lock_meas_path
  import pll_lock_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  lockCmd_t         cmd,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic [WIN_W-1:0] lockWin,
  input  logic [WIN_W-1:0] unlockWin,
  output measStat_t        stat,
  output logic             periodErr
);

  localparam int CW = WIN_W + 1;
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] ALL_ONES = '1;

  measState_t    state;
  logic          firstIsRef;
  logic [CW-1:0] tickCnt;
  logic [CW-1:0] periodCnt;
  logic [CW-1:0] satVal;
  logic [CW-1:0] lockExt;
  logic [CW-1:0] unlockExt;
  logic [CW-1:0] gap;
  logic          otherEdge;
  logic          finish;

  assign lockExt   = {1'b0, lockWin};
  assign unlockExt = {1'b0, unlockWin};
  assign satVal    = unlockExt + ONE;
  assign otherEdge = firstIsRef ? fbEdge : refEdge;

  // Completion of a compare cycle and its measured gap
  always_comb begin
    finish = 1'b0;
    gap    = '0;
    if (state == MEAS_IDLE) begin
      if (refEdge && fbEdge) begin
        finish = 1'b1;
        gap    = '0;
      end
    end else begin
      if (tickCnt >= satVal) begin
        finish = 1'b1;
        gap    = satVal;
      end else if (otherEdge) begin
        finish = 1'b1;
        gap    = tickCnt;
      end
    end
  end

  assign stat.done         = finish && !cmd.clear;
  assign stat.withinLock   = gap < lockExt;
  assign stat.beyondUnlock = gap > unlockExt;

  // Edge-gap tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= MEAS_IDLE;
      tickCnt    <= '0;
      firstIsRef <= 1'b0;
    end else if (cmd.clear) begin
      state      <= MEAS_IDLE;
      tickCnt    <= '0;
      firstIsRef <= 1'b0;
    end else begin
      case (state)
        MEAS_IDLE: begin
          if (refEdge ^ fbEdge) begin
            state      <= MEAS_WAIT;
            tickCnt    <= ONE;
            firstIsRef <= refEdge;
          end
        end
        default: begin
          if (finish) begin
            state   <= MEAS_IDLE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + ONE;
          end
        end
      endcase
    end
  end

  // Reference period monitor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= ALL_ONES;
      periodErr <= 1'b0;
    end else if (cmd.clear) begin
      periodCnt <= ALL_ONES;
      periodErr <= 1'b0;
    end else if (refEdge) begin
      periodErr <= periodCnt <= unlockExt;
      periodCnt <= ONE;
    end else if (periodCnt != ALL_ONES) begin
      periodCnt <= periodCnt + ONE;
    end
  end

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import pll_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] countSel,
  input  measStat_t  stat,
  output lockCmd_t   cmd,
  output logic       locked,
  output logic       inWindow
);

  logic [RUN_W-1:0] goodCnt;
  logic [RUN_W-1:0] nextCnt;
  logic [RUN_W-1:0] target;

  assign cmd.clear = !enable;
  assign target    = runTarget(countSel);
  assign nextCnt   = (goodCnt == {RUN_W{1'b1}}) ? goodCnt : goodCnt + RUN_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt  <= '0;
      locked   <= 1'b0;
      inWindow <= 1'b0;
    end else if (!enable) begin
      goodCnt  <= '0;
      locked   <= 1'b0;
      inWindow <= 1'b0;
    end else begin
      inWindow <= stat.done && stat.withinLock;
      if (stat.done) begin
        if (stat.withinLock) begin
          goodCnt <= nextCnt;
          if (nextCnt >= target) begin
            locked <= 1'b1;
          end
        end else begin
          goodCnt <= '0;
          if (stat.beyondUnlock) begin
            locked <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import pll_lock_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic [WIN_W-1:0] lockWin,
  input  logic [WIN_W-1:0] unlockWin,
  input  logic [1:0]       countSel,
  output logic             locked,
  output logic             inWindow,
  output logic             cfgError
);

  lockCmd_t  cmd;
  measStat_t stat;
  logic      periodErr;

  lock_meas_path #(.WIN_W(WIN_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .refEdge   (refEdge),
    .fbEdge    (fbEdge),
    .lockWin   (lockWin),
    .unlockWin (unlockWin),
    .stat      (stat),
    .periodErr (periodErr)
  );

  lock_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .countSel (countSel),
    .stat     (stat),
    .cmd      (cmd),
    .locked   (locked),
    .inWindow (inWindow)
  );

  assign cfgError = periodErr || (unlockWin <= lockWin);

endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk #(
  parameter int WIN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [WIN_W-1:0] lockWin,
  input logic [WIN_W-1:0] unlockWin,
  input logic             locked,
  input logic             inWindow,
  input logic             cfgError
);

  AST_LOCK_RISES_ON_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> inWindow); // R3

  AST_LOCK_FALLS_ON_BAD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> !inWindow); // R5

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!locked && !inWindow)); // R9

  AST_ZERO_WINDOW_NO_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lockWin) == '0) |-> !inWindow); // R2

  AST_WINDOW_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (unlockWin <= lockWin) |-> cfgError); // R8

endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(.WIN_W(WIN_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .lockWin   (lockWin),
  .unlockWin (unlockWin),
  .locked    (locked),
  .inWindow  (inWindow),
  .cfgError  (cfgError)
);

// File: tb/pll_lock_monitor_bench.sv
module pll_lock_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic refEdge = 1'b0;
  logic fbEdge = 1'b0;
  logic [WIN_W-1:0] lockWin = 8'd6;
  logic [WIN_W-1:0] unlockWin = 8'd14;
  logic [1:0] countSel = 2'd0;
  logic locked, inWindow, cfgError;

  int checks = 0;
  int errors = 0;
  int expCnt = 0;
  bit expLocked = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_monitor #(.WIN_W(WIN_W)) u_pll_lock_monitor (
    .clk(clk), .rstN(rstN), .enable(enable), .refEdge(refEdge), .fbEdge(fbEdge),
    .lockWin(lockWin), .unlockWin(unlockWin), .countSel(countSel),
    .locked(locked), .inWindow(inWindow), .cfgError(cfgError)
  );

  function automatic int benchTarget(input logic [1:0] sel);
    case (sel)
      2'd0: return 5;
      2'd1: return 16;
      2'd2: return 64;
      default: return 255;
    endcase
  endfunction

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelClear();
    expCnt = 0;
    expLocked = 1'b0;
  endtask

  // One compare cycle; d > unlockWin means the second edge never arrives
  task automatic runCycle(input int d, input bit refFirst, input string req);
    int u = int'(unlockWin);
    bit timeout = (d > u);
    int lim = timeout ? u + 1 : d;
    int meas = timeout ? u + 1 : d;
    bit good;
    for (int i = 0; i <= lim; i++) begin
      @(negedge clk);
      refEdge = (d == 0) || (i == 0 && refFirst) || (i == lim && !timeout && !refFirst);
      fbEdge  = (d == 0) || (i == 0 && !refFirst) || (i == lim && !timeout && refFirst);
    end
    @(negedge clk);
    refEdge = 1'b0;
    fbEdge = 1'b0;
    good = meas < int'(lockWin);
    if (good) begin
      if (expCnt < 255) expCnt++;
      if (expCnt >= benchTarget(countSel)) expLocked = 1'b1;
    end else begin
      expCnt = 0;
      if (meas > u) expLocked = 1'b0;
    end
    checkEq({req, " inWindow"}, int'(inWindow), int'(good));
    checkEq({req, " locked"}, int'(locked), int'(expLocked));
    checkEq("R8 cfgError clear in legal setup", int'(cfgError), 0);
    repeat (u + 3) @(negedge clk);
  endtask

  task automatic disablePulse();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    checkEq("R9 locked after disable", int'(locked), 0);
    checkEq("R9 inWindow after disable", int'(inWindow), 0);
    enable = 1'b1;
    modelClear();
  endtask

  task automatic lockRunTest(input logic [1:0] sel);
    int n = benchTarget(sel);
    countSel = sel;
    for (int k = 0; k < n - 1; k++) runCycle(k % 5, k[0], "R4 run building");
    checkEq("R4 not locked one short of run", int'(locked), 0);
    runCycle(1, 1'b1, "R4 run complete");
    checkEq("R4 locked at run length", int'(locked), 1);
    disablePulse();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    checkEq("R9 locked in reset", int'(locked), 0);
    checkEq("R9 inWindow in reset", int'(inWindow), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R9 cfgError after reset", int'(cfgError), 0);
    enable = 1'b1;
    @(negedge clk);

    // R3 / R4 run of 5, mixed edge order, R1 gap of 0
    countSel = 2'd0;
    runCycle(2, 1'b1, "R3 good 1");
    runCycle(0, 1'b1, "R1 same-cycle edges");
    runCycle(5, 1'b0, "R1 fb first below window");
    runCycle(3, 1'b0, "R3 good 4");
    checkEq("R3 not locked after 4", int'(locked), 0);
    runCycle(1, 1'b1, "R3 good 5");
    checkEq("R3 locked after 5", int'(locked), 1);

    // R5 hysteresis, R2 boundary at lockWin
    runCycle(6, 1'b1, "R2 gap equal lockWin");
    runCycle(10, 1'b0, "R5 between windows");
    runCycle(14, 1'b1, "R5 gap equal unlockWin");
    checkEq("R5 still locked", int'(locked), 1);
    runCycle(40, 1'b0, "R7 timeout clears lock");
    checkEq("R7 lock dropped", int'(locked), 0);

    // R6 between-window cycle resets the run while unlocked
    for (int k = 0; k < 4; k++) runCycle(2, 1'b1, "R6 pre run");
    runCycle(8, 1'b1, "R6 between resets run");
    for (int k = 0; k < 4; k++) runCycle(4, 1'b0, "R6 post run");
    checkEq("R6 not locked after broken run", int'(locked), 0);
    runCycle(0, 1'b0, "R6 fifth after reset");
    checkEq("R6 locked after fresh run", int'(locked), 1);
    disablePulse();

    // R4 other run lengths
    lockRunTest(2'd1);
    lockRunTest(2'd2);
    lockRunTest(2'd3);

    // R8 window ordering
    @(negedge clk);
    unlockWin = 8'd6;
    #1;
    checkEq("R8 unlock equal lock", int'(cfgError), 1);
    unlockWin = 8'd14;
    #1;
    checkEq("R8 ordering restored", int'(cfgError), 0);

    // R8 compare period too short
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      refEdge = 1'b1;
      @(negedge clk);
      refEdge = 1'b0;
      repeat (3) @(negedge clk);
    end
    checkEq("R8 short reference period", int'(cfgError), 1);
    repeat (20) @(negedge clk);
    disablePulse();
    checkEq("R9 period error cleared", int'(cfgError), 0);
    repeat (5) @(negedge clk);

    // Random mix
    countSel = 2'd0;
    for (int k = 0; k < 400; k++) begin
      int r = int'($urandom_range(0, 99));
      int d;
      if (k % 60 == 59) begin
        countSel = 2'($urandom_range(0, 1));
      end
      if (r < 88) d = int'($urandom_range(0, 5));
      else if (r < 97) d = int'($urandom_range(6, 14));
      else d = 30;
      runCycle(d, 1'($urandom_range(0, 1)), "R5 random mix");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule